// File: doc/BRIEF.md
# Diagnostic Mode Pin Remapper

This block supervises the factory calibration and diagnostic state of a smoke alarm controller. A digital request input stands in for the electrical entry condition. The request counts only if it stays asserted across a full period of the slow oscillator, which reaches the block as a one-cycle `osc_tick` strobe. If the request is dropped, the block returns to normal operation at the next tick.

While diagnostic mode is active, three pins that normally do other work become control inputs:

- **I/O pin:** turns on routing of the amplifier output.
- **Hush pin:** picks the gain (normal or supervisory) and the output the amplifier drives.
- **Feedback pin:** adds a 10 % hysteresis step to the normal gain.

The horn drive shows a three-in-a-row smoke integrator, fed by external detection results. The LED drive mirrors an external low-battery comparator bit.

With the I/O pin low, four rising edges on the hush pin move the block into a vendor test state. Only reset leaves that state. Request, I/O, hush and feedback are asynchronous pins and pass through a synchronizer of `SYNC_STAGES` flops before any use.

Top module: `diag_pin_remap`

## Requirements
- R1: After reset, `diag_active`, `vendor_test` and every remapped output are low.
- R2: Diagnostic mode is entered at a tick only if the synchronized request was high at the previous tick and stayed high continuously since then. A request that drops between ticks restarts qualification.
- R3: In diagnostic mode, a low synchronized request at a tick returns the block to normal mode on that tick.
- R4: In diagnostic mode with I/O high and hush low, `amp_route_en`=1, `amp_route_sel`=0 (output 1) and `gain_super`=0.
- R5: In diagnostic mode with I/O high and hush high, `amp_route_en`=1, `amp_route_sel`=1 (output 2) and `gain_super`=1.
- R6: `gain_hyst` is 1 only in diagnostic mode with I/O high, hush low and feedback high. Feedback has no effect in any other case.
- R7: In diagnostic mode with I/O low, `amp_route_en`, `amp_route_sel`, `gain_super` and `gain_hyst` are all 0.
- R8: In diagnostic mode with I/O low, the fourth rising edge of hush sets `vendor_test`. The edge count is cleared while I/O is high or while the block is outside diagnostic mode.
- R9: The vendor test state holds until reset, whatever the request does. In that state `diag_active` and all remapped outputs are 0.
- R10: In diagnostic mode, `horn_drv` goes high after three consecutive `smoke_vld` strobes with `smoke_det`=1. It goes low after three consecutive strobes with `smoke_det`=0. A mixed run does not change it.
- R11: In diagnostic mode, `led_drv` equals `low_batt`.
- R12: Outside diagnostic mode, all remapped outputs are 0, whatever the pin inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| diag_req | input | 1 | Diagnostic entry request (asynchronous) |
| io_pin | input | 1 | I/O pin level (asynchronous) |
| hush_pin | input | 1 | Hush pin level (asynchronous) |
| fb_pin | input | 1 | Feedback pin level (asynchronous) |
| smoke_vld | input | 1 | Strobe marking a new detection result |
| smoke_det | input | 1 | Detection result, 1 = smoke |
| low_batt | input | 1 | Low-battery comparator bit |
| diag_active | output | 1 | Diagnostic mode active |
| vendor_test | output | 1 | Vendor test state reached |
| amp_route_en | output | 1 | Amplifier output routing enable |
| amp_route_sel | output | 1 | 0 = output 1, 1 = output 2 |
| gain_super | output | 1 | Supervisory gain select |
| gain_hyst | output | 1 | 10 % hysteresis gain step |
| horn_drv | output | 1 | Integrator state on horn pin |
| led_drv | output | 1 | Low-battery indication on LED pin |

## Verification
The assertions assume that `osc_tick`, `smoke_vld`, `smoke_det` and `low_batt` are synchronous to `clk`, and that `osc_tick` is a single-cycle pulse. The stimulus drives every input on the falling clock edge. It pulses the tick and the detection strobe for exactly one cycle each. It holds each pin level for several cycles before the next change, so the synchronizer never sees a pulse shorter than its depth and every hush edge is counted.

// File: rtl/diag_remap_pkg.sv
package diag_remap_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_DIAG   = 2'd1,
    MODE_VENDOR = 2'd2
  } diag_mode_e;

  typedef struct packed {
    logic req;
    logic io;
    logic hush;
    logic fb;
  } pin_bundle_t;

  localparam int PIN_COUNT = $bits(pin_bundle_t);
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/diag_mode_ctrl.sv
module diag_mode_ctrl
  import diag_remap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       req_s,
  input  logic       vendor_go,
  output diag_mode_e mode
);
  diag_mode_e mode_q, mode_d;
  logic       armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!req_s)        armed_d = 1'b0;
    else if (osc_tick) armed_d = 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL: if (osc_tick && req_s && armed_q) mode_d = MODE_DIAG;
      MODE_DIAG: begin
        if (vendor_go)              mode_d = MODE_VENDOR;
        else if (osc_tick && !req_s) mode_d = MODE_NORMAL;
      end
      MODE_VENDOR: mode_d = MODE_VENDOR;
      default:     mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign mode = mode_q;

  // R2: entry only on a tick with the request high and held since an earlier tick
  a_r2_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DIAG && $past(mode_q) == MODE_NORMAL) |->
      ($past(osc_tick) && $past(req_s) && $past(armed_q)));

  // R3: leaving to normal happens only on a tick with the request low
  a_r3_exit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && $past(mode_q) == MODE_DIAG) |->
      ($past(osc_tick) && !$past(req_s)));

  // R9: vendor state is sticky
  a_r9_vendor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_VENDOR) |-> (mode_q == MODE_VENDOR));
endmodule

// File: rtl/hush_edge_counter.sv
module hush_edge_counter #(
  parameter int EXIT_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_diag,
  input  logic io_s,
  input  logic hush_s,
  output logic vendor_go
);
  localparam int CW = $clog2(EXIT_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EXIT_EDGES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q;
  logic          clr, rise;

  assign clr  = !in_diag || io_s;
  assign rise = hush_s && !prev_q;

  always_comb begin
    cnt_d     = cnt_q;
    vendor_go = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (rise) begin
      if (cnt_q == LAST) begin
        vendor_go = 1'b1;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= hush_s;
    end
  end

  // R8: count stays below the exit threshold
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(EXIT_EDGES));

  // R8: count is zero after a cycle with I/O high
  a_r8_clear_on_io: assert property (@(posedge clk) disable iff (!rst_n)
    $past(io_s) |-> (cnt_q == '0));
endmodule

// File: rtl/smoke_integrator.sv
module smoke_integrator #(
  parameter int CONSEC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic smoke_vld,
  input  logic smoke_det,
  output logic state
);
  localparam int CW = $clog2(CONSEC + 1);
  localparam logic [CW-1:0] LAST = CW'(CONSEC - 1);

  logic [CW-1:0] run_q, run_d;
  logic          state_q, state_d;

  always_comb begin
    run_d   = run_q;
    state_d = state_q;
    if (!enable) begin
      run_d   = '0;
      state_d = 1'b0;
    end else if (smoke_vld) begin
      if (smoke_det == state_q) begin
        run_d = '0;
      end else if (run_q == LAST) begin
        run_d   = '0;
        state_d = smoke_det;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      state_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R10: output rises only on a strobe carrying a detection
  a_r10_rise_on_det: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q) |-> ($past(smoke_vld) && $past(smoke_det)));

  // R10: output falls only on a clear strobe or when disabled
  a_r10_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_q) |-> (!$past(enable) || ($past(smoke_vld) && !$past(smoke_det))));
endmodule

// File: rtl/diag_pin_remap.sv
module diag_pin_remap
  import diag_remap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EXIT_EDGES  = 4,
  parameter int SMOKE_RUN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic diag_req,
  input  logic io_pin,
  input  logic hush_pin,
  input  logic fb_pin,
  input  logic smoke_vld,
  input  logic smoke_det,
  input  logic low_batt,
  output logic diag_active,
  output logic vendor_test,
  output logic amp_route_en,
  output logic amp_route_sel,
  output logic gain_super,
  output logic gain_hyst,
  output logic horn_drv,
  output logic led_drv
);
  pin_bundle_t pins_raw, pins_s;
  diag_mode_e  mode;
  logic        in_diag, vendor_go, integ_state;

  assign pins_raw = '{req: diag_req, io: io_pin, hush: hush_pin, fb: fb_pin};

  pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  diag_mode_ctrl i_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .req_s     (pins_s.req),
    .vendor_go (vendor_go),
    .mode      (mode)
  );

  assign in_diag = (mode == MODE_DIAG);

  hush_edge_counter #(.EXIT_EDGES(EXIT_EDGES)) i_hush (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_diag   (in_diag),
    .io_s      (pins_s.io),
    .hush_s    (pins_s.hush),
    .vendor_go (vendor_go)
  );

  smoke_integrator #(.CONSEC(SMOKE_RUN)) i_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (in_diag),
    .smoke_vld (smoke_vld),
    .smoke_det (smoke_det),
    .state     (integ_state)
  );

  always_comb begin
    amp_route_en  = 1'b0;
    amp_route_sel = 1'b0;
    gain_super    = 1'b0;
    gain_hyst     = 1'b0;
    horn_drv      = 1'b0;
    led_drv       = 1'b0;
    if (in_diag) begin
      horn_drv = integ_state;
      led_drv  = low_batt;
      if (pins_s.io) begin
        amp_route_en = 1'b1;
        if (pins_s.hush) begin
          amp_route_sel = 1'b1;
          gain_super    = 1'b1;
        end else begin
          gain_hyst = pins_s.fb;
        end
      end
    end
  end

  assign diag_active = in_diag;
  assign vendor_test = (mode == MODE_VENDOR);

  // R6: hysteresis only with routing on and normal gain
  a_r6_hyst_context: assert property (@(posedge clk) disable iff (!rst_n)
    gain_hyst |-> (amp_route_en && !gain_super && !amp_route_sel));

  // R5: supervisory gain always pairs with output 2
  a_r5_super_route: assert property (@(posedge clk) disable iff (!rst_n)
    gain_super |-> (amp_route_en && amp_route_sel));

  // R12: outside diagnostic mode the remapped outputs are quiet
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_active |-> !(amp_route_en || amp_route_sel || gain_super ||
                       gain_hyst || horn_drv || led_drv));

  // R9: the two mode indications never overlap
  a_r9_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(diag_active && vendor_test));
endmodule

// File: tb/test_diag_pin_remap.sv
`timescale 1ns/1ps
module test_diag_pin_remap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, diag_req = 1'b0, io_pin = 1'b0, hush_pin = 1'b0, fb_pin = 1'b0;
  logic smoke_vld = 1'b0, smoke_det = 1'b0, low_batt = 1'b0;
  logic diag_active, vendor_test, amp_route_en, amp_route_sel;
  logic gain_super, gain_hyst, horn_drv, led_drv;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  diag_pin_remap i_diag_pin_remap (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .diag_req(diag_req),
    .io_pin(io_pin), .hush_pin(hush_pin), .fb_pin(fb_pin),
    .smoke_vld(smoke_vld), .smoke_det(smoke_det), .low_batt(low_batt),
    .diag_active(diag_active), .vendor_test(vendor_test),
    .amp_route_en(amp_route_en), .amp_route_sel(amp_route_sel),
    .gain_super(gain_super), .gain_hyst(gain_hyst),
    .horn_drv(horn_drv), .led_drv(led_drv)
  );

  function automatic logic [7:0] outs();
    return {diag_active, vendor_test, amp_route_en, amp_route_sel,
            gain_super, gain_hyst, horn_drv, led_drv};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // let pin changes pass the synchronizer
  task automatic settle();
    wait_clk(4);
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); osc_tick = 1'b1;
    @(negedge clk); osc_tick = 1'b0;
    #1;
  endtask

  task automatic strobe(logic det);
    @(negedge clk); smoke_vld = 1'b1; smoke_det = det;
    @(negedge clk); smoke_vld = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; diag_req = 0; io_pin = 0; hush_pin = 0; fb_pin = 0;
    osc_tick = 0; smoke_vld = 0; smoke_det = 0; low_batt = 0;
    wait_clk(3);
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic enter_diag();
    @(negedge clk); diag_req = 1'b1;
    settle();
    tick();
    tick();
    settle();
  endtask

  task automatic t_reset();
    check("R1 reset outputs", outs(), 8'b0);
  endtask

  task automatic t_normal_ignore();
    @(negedge clk); io_pin = 1; hush_pin = 1; fb_pin = 1; low_batt = 1;
    settle();
    check("R12 normal io/hush/fb high", outs(), 8'b0);
    strobe(1); strobe(1); strobe(1);
    check("R12 normal smoke run", outs(), 8'b0);
    @(negedge clk); io_pin = 0; hush_pin = 0; fb_pin = 0; low_batt = 0;
    settle();
  endtask

  task automatic t_entry();
    @(negedge clk); diag_req = 1'b1;
    settle();
    tick();
    wait_clk(2);
    check("R2 one tick not enough", outs(), 8'b0);
    @(negedge clk); diag_req = 1'b0;
    settle();
    @(negedge clk); diag_req = 1'b1;
    settle();
    tick();
    wait_clk(2);
    check("R2 broken hold restarts", outs(), 8'b0);
    tick();
    wait_clk(1);
    check("R2 full period entry", outs(), 8'b1000_0000);
  endtask

  task automatic t_routing();
    @(negedge clk); io_pin = 1; hush_pin = 0; fb_pin = 0;
    settle();
    check("R4 io high hush low", outs(), 8'b1010_0000);
    @(negedge clk); fb_pin = 1;
    settle();
    check("R6 hysteresis on", outs(), 8'b1010_0100);
    @(negedge clk); hush_pin = 1;
    settle();
    check("R5 io high hush high fb ignored", outs(), 8'b1011_1000);
    @(negedge clk); fb_pin = 0;
    settle();
    check("R5 supervisory gain", outs(), 8'b1011_1000);
    @(negedge clk); io_pin = 0; hush_pin = 0; fb_pin = 1;
    settle();
    check("R7 io low fb ignored (R6)", outs(), 8'b1000_0000);
    @(negedge clk); fb_pin = 0;
    settle();
  endtask

  task automatic t_integrator();
    strobe(1); strobe(1);
    check("R10 two detections", {7'b0, horn_drv}, 8'd0);
    strobe(1);
    check("R10 three detections", {7'b0, horn_drv}, 8'd1);
    strobe(0); strobe(0);
    check("R10 two clears hold", {7'b0, horn_drv}, 8'd1);
    strobe(0);
    check("R10 three clears", {7'b0, horn_drv}, 8'd0);
    strobe(1); strobe(1); strobe(0); strobe(1); strobe(1);
    check("R10 mixed run", {7'b0, horn_drv}, 8'd0);
    strobe(0);
  endtask

  task automatic t_led();
    @(negedge clk); low_batt = 1'b1; #1;
    check("R11 low battery on", {7'b0, led_drv}, 8'd1);
    @(negedge clk); low_batt = 1'b0; #1;
    check("R11 low battery off", {7'b0, led_drv}, 8'd0);
  endtask

  task automatic t_exit();
    @(negedge clk); diag_req = 1'b0;
    settle();
    check("R3 held until tick", outs(), 8'b1000_0000);
    tick();
    check("R3 normal after tick", outs(), 8'b0);
  endtask

  task automatic hush_pulse();
    @(negedge clk); hush_pin = 1'b1;
    settle();
    hush_pin = 1'b0;
    settle();
  endtask

  task automatic t_vendor();
    enter_diag();
    check("R2 re-entry", outs(), 8'b1000_0000);
    hush_pulse(); hush_pulse(); hush_pulse();
    @(negedge clk); io_pin = 1'b1;
    settle();
    io_pin = 1'b0;
    settle();
    hush_pulse(); hush_pulse(); hush_pulse();
    check("R8 io high cleared count", outs(), 8'b1000_0000);
    hush_pulse();
    check("R8 fourth edge vendor", outs(), 8'b0100_0000);
    @(negedge clk); diag_req = 1'b0; io_pin = 1; hush_pin = 1; fb_pin = 1; low_batt = 1;
    settle();
    tick(); tick();
    wait_clk(2);
    check("R9 vendor sticky quiet", outs(), 8'b0100_0000);
    do_reset();
    check("R9 reset leaves vendor (R1)", outs(), 8'b0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_normal_ignore();
    t_entry();
    t_routing();
    t_integrator();
    t_led();
    t_exit();
    t_vendor();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule